// File: doc/BRIEF.md
# Dual-Channel Baud Clock Generator

This block derives the transmit and receive bit clocks of a LIN-capable UART from the system clock. A shared power-of-two prescaler produces a one-cycle tick strobe at the system clock divided by 1 to 128. Two independent 12-bit programmable counters consume those ticks, one for each direction. Each counter compares its count against the programmed divisor. On every match it toggles a divide-by-two flop, and that flop is the channel's baud clock.

Everything runs in one clock domain. The counters advance only on prescaler tick strobes. Each baud clock comes with a one-cycle strobe marking its rising edge, so shift logic can use the strobe as a clock enable.

Each channel is held cleared while its enable is low. The receive channel has an optional auto-baud wait. In that mode it holds at zero until the receive line is seen low, and from then on it counts freely.

Top module: `baud_gen_dual`

## Requirements
- R1: The prescaler select value s (0 to 7) gives one tick every 2^s system clocks. A channel counter advances only on ticks.
- R2: While the module enable is low, no ticks occur, the prescaler phase restarts, and both channels hold their count and baud level.
- R3: With an effective divisor D, a running channel toggles its baud clock every D ticks. The baud period is therefore 2·D ticks.
- R4: A divisor value of 0 behaves exactly like a divisor of 1.
- R5: While the transmit enable is low, the transmit baud output is 0 and its counter is cleared. After enabling, the first rising edge comes after a full D ticks.
- R6: While the receive enable is low, the receive baud output is 0 and its counter is cleared. After enabling, the first rising edge comes after a full D ticks.
- R7: With auto-baud set and receive enabled, the receive counter holds at zero while the receive line is high. From the first cycle the line is low it counts, and it keeps counting regardless of the line until receive is disabled.
- R8: With auto-baud clear, the receive line has no effect on the receive channel.
- R9: Each strobe output is high for exactly the one cycle in which its baud output changes from 0 to 1. At all other times it is low.
- R10: A match occurs when count ≥ D−1. A divisor lowered below the current count therefore ends the half period on the next tick.
- R11: The transmit and receive channels are independent: the enable and receive-line state of one never alter the other's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mod_en_i | input | 1 | Module enable; gates prescaler ticks |
| presc_sel_i | input | 3 | Prescaler select; divide by 2^value |
| divisor_i | input | 12 | Half-period divisor in ticks; 0 treated as 1 |
| tx_en_i | input | 1 | Transmit channel enable |
| rx_en_i | input | 1 | Receive channel enable |
| autobaud_i | input | 1 | Receive waits for low line before counting |
| rxd_i | input | 1 | Receive serial line |
| tx_baud_o | output | 1 | Transmit baud clock |
| tx_stb_o | output | 1 | One-cycle strobe on transmit baud rising edge |
| rx_baud_o | output | 1 | Receive baud clock |
| rx_stb_o | output | 1 | One-cycle strobe on receive baud rising edge |

## Verification
A wrong count or divider flop shows as a baud edge that comes early or late. The error reaches the ports within one half period, at most D ticks later. A fault in the prescaler phase shifts every following edge by some cycles, and the per-cycle comparison catches it on the first misplaced toggle. An arming flop stuck set or clear shows as receive edges that start before the line falls, or never start, within D ticks of the stimulus.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int unsigned SEL_W_DEF = 3;
  localparam int unsigned DIV_W_DEF = 12;

  typedef enum logic {
    CH_TX = 1'b0,
    CH_RX = 1'b1
  } ch_kind_e;
endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int unsigned SEL_W = baud_pkg::SEL_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;

  for (genvar gi = 0; gi < CNT_W; gi++) begin : g_mask
    assign mask[gi] = (sel_i > SEL_W'(gi));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && ((cnt_q & mask) == mask);

  // divide-by-2 select never ticks twice in a row
  p_tick_gap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && sel_i == SEL_W'(1) && $stable(sel_i) && en_i) |=> !tick_o);

  p_phase_restart_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/baud_channel.sv
module baud_channel #(
  parameter int unsigned  DIV_W = baud_pkg::DIV_W_DEF,
  parameter baud_pkg::ch_kind_e KIND = baud_pkg::CH_TX
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             wait_i,
  input  logic             go_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             baud_o,
  output logic             stb_o
);
  logic [DIV_W-1:0] cnt_q, div_eff, lim;
  logic             baud_q, stb_q, armed_q;
  logic             start, run, match, step;

  if (KIND == baud_pkg::CH_RX) begin : g_wait
    assign start = !wait_i || go_i;
  end else begin : g_nowait
    assign start = 1'b1;
  end

  assign run     = armed_q || start;
  assign div_eff = (div_i == '0) ? DIV_W'(1) : div_i;
  assign lim     = div_eff - 1'b1;
  assign match   = (cnt_q >= lim);
  assign step    = en_i && tick_i && run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      baud_q  <= 1'b0;
      stb_q   <= 1'b0;
      armed_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q   <= '0;
      baud_q  <= 1'b0;
      stb_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= armed_q || start;
      stb_q   <= step && match && !baud_q;
      if (step) begin
        if (match) begin
          cnt_q  <= '0;
          baud_q <= !baud_q;
        end else begin
          cnt_q  <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign baud_o = baud_q;
  assign stb_o  = stb_q;

  p_stb_on_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |-> (baud_q && !$past(baud_q)));

  p_rise_has_stb_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (baud_q && !$past(baud_q)) |-> stb_q);

  p_disabled_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0 && !baud_q));

  p_hold_no_tick_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> ($stable(cnt_q) && $stable(baud_q)));

  p_wait_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !run) |=> (cnt_q == '0 && !baud_q));

  p_no_overflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !match) |=> (cnt_q != '0));
endmodule

// File: rtl/baud_gen_dual.sv
module baud_gen_dual #(
  parameter int unsigned SEL_W = baud_pkg::SEL_W_DEF,
  parameter int unsigned DIV_W = baud_pkg::DIV_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mod_en_i,
  input  logic [SEL_W-1:0] presc_sel_i,
  input  logic [DIV_W-1:0] divisor_i,
  input  logic             tx_en_i,
  input  logic             rx_en_i,
  input  logic             autobaud_i,
  input  logic             rxd_i,
  output logic             tx_baud_o,
  output logic             tx_stb_o,
  output logic             rx_baud_o,
  output logic             rx_stb_o
);
  logic tick;

  baud_prescaler #(.SEL_W(SEL_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (mod_en_i),
    .sel_i  (presc_sel_i),
    .tick_o (tick)
  );

  baud_channel #(.DIV_W(DIV_W), .KIND(baud_pkg::CH_TX)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .en_i   (tx_en_i),
    .wait_i (1'b0),
    .go_i   (1'b0),
    .div_i  (divisor_i),
    .baud_o (tx_baud_o),
    .stb_o  (tx_stb_o)
  );

  baud_channel #(.DIV_W(DIV_W), .KIND(baud_pkg::CH_RX)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .en_i   (rx_en_i),
    .wait_i (autobaud_i),
    .go_i   (!rxd_i),
    .div_i  (divisor_i),
    .baud_o (rx_baud_o),
    .stb_o  (rx_stb_o)
  );

  p_no_tick_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mod_en_i && tx_en_i) |=> ($stable(tx_baud_o) && !tx_stb_o));
endmodule

// File: tb/sim_baud_gen_dual.sv
module sim_baud_gen_dual;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mod_en = 1'b0;
  logic [2:0]  sel = '0;
  logic [11:0] div = '0;
  logic        tx_en = 1'b0, rx_en = 1'b0, ab = 1'b0, rxd = 1'b1;
  logic        tx_baud, tx_stb, rx_baud, rx_stb;

  int    n_vec = 0, n_fail = 0, cyc = 0;
  int    prev_tx_stb = 0, tx_gap = 0, rx_stb_cnt = 0;
  bit    checking = 1'b0;
  string cur_req = "R5";

  // reference model state
  int pc;
  int m_cnt [2];
  bit m_baud [2], m_stb [2], m_arm [2];

  always #2 clk = ~clk;

  baud_gen_dual u0 (
    .clk_i(clk), .rst_ni(rst_n), .mod_en_i(mod_en), .presc_sel_i(sel),
    .divisor_i(div), .tx_en_i(tx_en), .rx_en_i(rx_en), .autobaud_i(ab),
    .rxd_i(rxd), .tx_baud_o(tx_baud), .tx_stb_o(tx_stb),
    .rx_baud_o(rx_baud), .rx_stb_o(rx_stb)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc = 0;
      for (int c = 0; c < 2; c++) begin
        m_cnt[c] = 0; m_baud[c] = 0; m_stb[c] = 0; m_arm[c] = 0;
      end
    end else begin
      bit tk, en, st, rn;
      int d;
      tk = mod_en && ((pc % (1 << sel)) == ((1 << sel) - 1));
      pc = mod_en ? (pc + 1) % 128 : 0;
      d  = (div == 0) ? 1 : int'(div);
      for (int c = 0; c < 2; c++) begin
        en = (c == 0) ? tx_en : rx_en;
        st = (c == 0) ? 1'b1 : (!ab || !rxd);
        if (!en) begin
          m_cnt[c] = 0; m_baud[c] = 0; m_stb[c] = 0; m_arm[c] = 0;
        end else begin
          rn = m_arm[c] || st;
          m_arm[c] = rn;
          m_stb[c] = 0;
          if (tk && rn) begin
            if (m_cnt[c] >= d - 1) begin
              m_cnt[c] = 0;
              m_baud[c] = !m_baud[c];
              m_stb[c] = m_baud[c];
            end else m_cnt[c]++;
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d @%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && checking) begin
      int act, exp;
      act = {tx_baud, tx_stb, rx_baud, rx_stb};
      exp = {m_baud[0], m_stb[0], m_baud[1], m_stb[1]};
      chk(act == exp, cur_req, "outputs{txb,txs,rxb,rxs}", act, exp);
      if (tx_stb) begin tx_gap = cyc - prev_tx_stb; prev_tx_stb = cyc; end
      if (rx_stb) rx_stb_cnt++;
    end
  end

  task automatic run(input string r, input int n);
    cur_req = r;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({tx_baud, tx_stb, rx_baud, rx_stb} == 0, "R5", "reset outputs", {tx_baud, tx_stb, rx_baud, rx_stb}, 0);
    rst_n = 1'b1;
    checking = 1'b1;
    // R3: basic half period, no prescale
    mod_en = 1; sel = 0; div = 12'd3; tx_en = 1; rx_en = 1;
    run("R3", 200);
    // R1: divide by 4, D=5 -> 40 cycles per rising edge
    sel = 3'd2; div = 12'd5;
    run("R1", 400);
    chk(tx_gap == 40, "R1", "tx strobe spacing", tx_gap, 40);
    // R4: divisor zero acts as one
    sel = 3'd0; div = 12'd0;
    run("R4", 60);
    chk(tx_gap == 2, "R4", "tx strobe spacing", tx_gap, 2);
    // R2: module disabled, everything frozen
    div = 12'd4; sel = 3'd1;
    run("R2", 30);
    mod_en = 0;
    run("R2", 100);
    mod_en = 1;
    run("R2", 100);
    // R5 / R11: tx disabled while rx runs, then re-enabled
    tx_en = 0;
    run("R11", 120);
    chk(tx_baud == 0, "R5", "tx baud while disabled", tx_baud, 0);
    tx_en = 1;
    run("R5", 150);
    // R6: rx disabled then re-enabled
    rx_en = 0;
    run("R6", 80);
    rx_en = 1;
    run("R6", 150);
    // R7: auto-baud wait
    rx_en = 0; ab = 1; rxd = 1;
    run("R7", 3);
    rx_en = 1; rx_stb_cnt = 0;
    run("R7", 150);
    chk(rx_stb_cnt == 0, "R7", "rx strobes before line low", rx_stb_cnt, 0);
    rxd = 0;
    run("R7", 1);
    rxd = 1;
    run("R7", 150);
    chk(rx_stb_cnt > 0, "R7", "rx running after line low", rx_stb_cnt, 1);
    // R8: auto-baud off, line toggling ignored
    rx_en = 0; ab = 0;
    run("R8", 3);
    rx_en = 1;
    for (int i = 0; i < 40; i++) begin
      rxd = i[1];
      run("R8", 3);
    end
    rxd = 1;
    // R10: divisor lowered below running count
    sel = 3'd0; div = 12'd200; tx_en = 0; rx_en = 0;
    run("R10", 2);
    tx_en = 1; rx_en = 1;
    run("R10", 100);
    div = 12'd10;
    run("R10", 120);
    // R9: strobe width at larger prescale
    sel = 3'd3; div = 12'd2;
    run("R9", 300);
    checking = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule